// File: doc/BRIEF.md
# Rotated Immediate Encodability Checker

The block decides whether a 32-bit constant can be written as an 8-bit unsigned value that is rotated right by an even number of bit positions between 0 and 30. When such a form exists, it returns the 8-bit value and a 4-bit field that holds half the rotation amount. An instruction encoder or a constant-materialisation step can use it to find out whether a constant fits into a single immediate operand.

The search is sequential. A start pulse captures the input constant. The block then tries one candidate rotation per clock, with the smallest rotation first. When a candidate fits, or when all sixteen candidates have failed, it raises `done` for one cycle. The result outputs hold their values until the next search completes.

Top module: `rimm_search`

## Requirements
- R1: After reset, `done`, `fit_ok`, `imm_out` and `rot_out` are all zero.
- R2: When `done` is high and `fit_ok` is high, `imm_out` zero-extended to 32 bits and rotated right by 2×`rot_out` positions equals the captured constant.
- R3: The reported `rot_out` is the smallest field value k (0..15) for which the constant is encodable with rotation 2k. In particular, every constant from 0 to 255 (for example 5 and 192) is reported with `rot_out` = 0 and `imm_out` equal to the constant.
- R4: A constant with no encodable form (for example 259 and 1025) gives `fit_ok` = 0, `imm_out` = 0 and `rot_out` = 0 when `done` is high.
- R5: `done` is high for exactly one cycle per accepted search.
- R6: Counting from the clock edge that accepts `start`, `done` rises after `rot_out`+1 further edges for an encodable constant and after 16 edges for a non-encodable one.
- R7: The constant is sampled only on the edge that accepts `start`. A `start` that arrives while a search is running is ignored, and changes on `const_in` during a search have no effect on the result.
- R8: The constant zero is reported as encodable, with `imm_out` = 0 and `rot_out` = 0, after one edge.
- R9: 768 is reported as encodable with `imm_out` = 3 and `rot_out` = 12 (a right rotation by 24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts a search when the block is idle |
| const_in | input | 32 | Constant to test, sampled on the edge that accepts start |
| done | output | 1 | One-cycle pulse that marks a finished search |
| fit_ok | output | 1 | High when an encodable form was found |
| imm_out | output | 8 | 8-bit value of the encoded form, zero when none is found |
| rot_out | output | 4 | Half of the right-rotation amount, zero when none is found |

## Verification
The assertions assume that a search counts as accepted only when `start` is high while no search is pending, or in the cycle in which `done` is high. The checker tracks its own copy of the accepted constant and its own cycle count on that basis, so it never reads the controller's state. The stimulus always raises `start` from idle and holds `start` only while a search is running. The one exception is a deliberate test of the ignored start, which ends before `done` so that no new search is accepted by accident. After each accept, the stimulus flips `const_in` to its complement so that any late sampling would show up as a wrong result.

// File: rtl/rimm_pkg.sv
// Package: shared controller state type for the rotated-immediate search.
// Assumes: a two-state controller (idle and scanning) is enough.
package rimm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;
endpackage

// File: rtl/rimm_cand.sv
// Module: rimm_cand
// Rotates the held word left by twice the candidate step and reports whether
// the result fits into the low IMM_W bits. A left rotation that fits means
// the word equals that low part rotated right by the same amount.
// Assumes: WORD_W is even and larger than IMM_W.
module rimm_cand #(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 8,
    localparam int ROT_W = $clog2(WORD_W / 2)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [ROT_W-1:0]  step,
    output logic              fits,
    output logic [IMM_W-1:0]  cand_imm
);
    logic [ROT_W:0]        shamt;
    logic [2*WORD_W-1:0]   doubled;
    logic [WORD_W-1:0]     rotated;

    // Rotate left by 2*step through a doubled copy of the word.
    always_comb begin
        shamt    = {step, 1'b0};
        doubled  = {word, word} << shamt;
        rotated  = doubled[2*WORD_W-1 -: WORD_W];
        fits     = (rotated[WORD_W-1:IMM_W] == '0);
        cand_imm = rotated[IMM_W-1:0];
    end
endmodule

// File: rtl/rimm_ctrl.sv
// Module: rimm_ctrl
// Sequencer of the search: captures the constant on an accepted start, then
// steps the candidate rotation once per clock until one fits or the last one
// has been tried. Starts that arrive while scanning are ignored.
// Assumes: synchronous active-low reset; fits is combinational from word/step.
module rimm_ctrl
    import rimm_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int ROT_W = $clog2(WORD_W / 2),
    localparam int LAST  = WORD_W / 2 - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] const_in,
    input  logic              fits,
    output logic [WORD_W-1:0] word_q,
    output logic [ROT_W-1:0]  step_q,
    output logic              hit,
    output logic              miss
);
    scan_state_e state_q;
    logic        at_last;

    // Decode the end-of-search conditions of the current candidate.
    always_comb begin
        at_last = (step_q == ROT_W'(LAST));
        hit     = (state_q == ST_SCAN) && fits;
        miss    = (state_q == ST_SCAN) && !fits && at_last;
    end

    // State, candidate step and captured constant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            word_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        word_q  <= const_in;
                        step_q  <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (fits || at_last) begin
                        state_q <= ST_IDLE;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rimm_result.sv
// Module: rimm_result
// Result register: pulses done for one cycle when a search ends and holds the
// encoded form, or zeros when no candidate fitted, until the next search ends.
// Assumes: hit and miss are never high together.
module rimm_result #(
    parameter int IMM_W = 8,
    parameter int ROT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             miss,
    input  logic [IMM_W-1:0] cand_imm,
    input  logic [ROT_W-1:0] step,
    output logic             done,
    output logic             fit_ok,
    output logic [IMM_W-1:0] imm_out,
    output logic [ROT_W-1:0] rot_out
);
    // Register the outcome of the search on its final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            fit_ok  <= 1'b0;
            imm_out <= '0;
            rot_out <= '0;
        end else begin
            done <= hit || miss;
            if (hit) begin
                fit_ok  <= 1'b1;
                imm_out <= cand_imm;
                rot_out <= step;
            end else if (miss) begin
                fit_ok  <= 1'b0;
                imm_out <= '0;
                rot_out <= '0;
            end
        end
    end
endmodule

// File: rtl/rimm_search.sv
// Module: rimm_search (top)
// Finds whether a constant equals an IMM_W-bit value rotated right by an even
// amount, trying the smallest rotation first at one candidate per clock.
// Assumes: start is a request that is honoured only when idle.
module rimm_search #(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 8,
    localparam int ROT_W = $clog2(WORD_W / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] const_in,
    output logic              done,
    output logic              fit_ok,
    output logic [IMM_W-1:0]  imm_out,
    output logic [ROT_W-1:0]  rot_out
);
    logic [WORD_W-1:0] word_q;
    logic [ROT_W-1:0]  step_q;
    logic              fits;
    logic [IMM_W-1:0]  cand_imm;
    logic              hit;
    logic              miss;

    rimm_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .const_in (const_in),
        .fits     (fits),
        .word_q   (word_q),
        .step_q   (step_q),
        .hit      (hit),
        .miss     (miss)
    );

    rimm_cand #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_cand (
        .word     (word_q),
        .step     (step_q),
        .fits     (fits),
        .cand_imm (cand_imm)
    );

    rimm_result #(.IMM_W(IMM_W), .ROT_W(ROT_W)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .miss     (miss),
        .cand_imm (cand_imm),
        .step     (step_q),
        .done     (done),
        .fit_ok   (fit_ok),
        .imm_out  (imm_out),
        .rot_out  (rot_out)
    );
endmodule

// File: rtl/rimm_search_chk.sv
// Module: rimm_search_chk
// Port-level checker for rimm_search. It keeps its own copy of the accepted
// constant and its own cycle count since the accept.
// Assumes: a start is accepted when no search is pending or while done is high.
module rimm_search_chk #(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 8,
    localparam int ROT_W = $clog2(WORD_W / 2),
    localparam int STEPS = WORD_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [WORD_W-1:0] const_in,
    input logic              done,
    input logic              fit_ok,
    input logic [IMM_W-1:0]  imm_out,
    input logic [ROT_W-1:0]  rot_out
);
    logic              run_q;
    logic [WORD_W-1:0] cap_q;
    logic [ROT_W+1:0]  cnt_q;
    logic              accept;
    logic [WORD_W-1:0] back;

    function automatic logic [WORD_W-1:0] rot_right(input logic [IMM_W-1:0] v,
                                                    input logic [ROT_W-1:0] half);
        logic [2*WORD_W-1:0] d;
        logic [WORD_W-1:0]   z;
        z = WORD_W'(v);
        d = {z, z} >> {half, 1'b0};
        return d[WORD_W-1:0];
    endfunction

    assign accept = start && (!run_q || done);
    assign back   = rot_right(imm_out, rot_out);

    // Track the accepted constant and the cycles elapsed in the search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cap_q <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            run_q <= 1'b1;
            cap_q <= const_in;
            cnt_q <= '0;
        end else begin
            if (done) run_q <= 1'b0;
            if (run_q && !done) cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r2_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
        done && fit_ok |-> back == cap_q);
    a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fit_ok |-> imm_out == '0 && rot_out == '0);
    a_r3_small_zero_rot: assert property (@(posedge clk) disable iff (!rst_n)
        done && cap_q < (WORD_W'(1) << IMM_W) |-> fit_ok && rot_out == '0);
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_latency_hit: assert property (@(posedge clk) disable iff (!rst_n)
        done && fit_ok |-> cnt_q == (ROT_W + 2)'(rot_out) + 1'b1);
    a_r6_latency_miss: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fit_ok |-> cnt_q == (ROT_W + 2)'(STEPS));
    a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && !done |-> cnt_q < (ROT_W + 2)'(STEPS));
    a_r7_done_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> run_q);
endmodule

bind rimm_search rimm_search_chk #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .const_in (const_in),
    .done     (done),
    .fit_ok   (fit_ok),
    .imm_out  (imm_out),
    .rot_out  (rot_out)
);

// File: tb/tb_rimm_search.sv
`timescale 1ns/1ps
module tb_rimm_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] const_in = '0;
    logic        done;
    logic        fit_ok;
    logic [7:0]  imm_out;
    logic [3:0]  rot_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rimm_search dut (
        .clk(clk), .rst_n(rst_n), .start(start), .const_in(const_in),
        .done(done), .fit_ok(fit_ok), .imm_out(imm_out), .rot_out(rot_out)
    );

    function automatic logic [31:0] ror32(input logic [31:0] v, input int n);
        logic [63:0] d;
        d = {v, v} >> n;
        return d[31:0];
    endfunction

    function automatic logic [31:0] rol32(input logic [31:0] v, input int n);
        logic [63:0] d;
        d = {v, v} << n;
        return d[63:32];
    endfunction

    // Expected form: smallest k whose low byte, rotated back right, rebuilds v.
    task automatic expect_form(input logic [31:0] v, output bit ok,
                               output logic [7:0] im, output logic [3:0] k);
        ok = 0; im = '0; k = '0;
        for (int r = 0; r < 16; r++) begin
            logic [7:0] c;
            c = rol32(v, 2 * r) & 32'hFF;
            if (!ok && ror32({24'h0, c}, 2 * r) == v) begin
                ok = 1; im = c; k = 4'(r);
            end
        end
    endtask

    task automatic chk(input bit good, input string req, input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one search from idle; after the accept, const_in is scrambled (R7).
    task automatic run_one(input logic [31:0] v, input bit noisy_start);
        bit ok; logic [7:0] im; logic [3:0] k;
        int cnt;
        expect_form(v, ok, im, k);
        @(negedge clk);
        start = 1'b1; const_in = v;
        @(negedge clk);
        cnt = 1;
        start = noisy_start;
        const_in = noisy_start ? 32'd5 : ~v;
        while (!done && cnt < 40) begin
            @(negedge clk);
            cnt++;
            if (noisy_start && cnt >= 10) start = 1'b0;
        end
        start = 1'b0;
        chk(done, "R6 done seen", done, 1);
        chk(fit_ok == ok, "R2/R4 fit_ok", fit_ok, ok);
        chk(imm_out == im, "R2/R3/R4 imm_out", imm_out, im);
        chk(rot_out == k, "R3/R4 rot_out", rot_out, k);
        chk(cnt == (ok ? int'(k) + 2 : 17), "R6 latency", cnt, ok ? int'(k) + 2 : 17);
        @(negedge clk);
        chk(!done, "R5 done one cycle", done, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!done && !fit_ok && imm_out == 0 && rot_out == 0, "R1 reset outputs",
            {done, fit_ok, imm_out, rot_out}, 0);

        // R8: zero input
        run_one(32'd0, 0);
        chk(fit_ok && imm_out == 0 && rot_out == 0, "R8 zero", {fit_ok, imm_out, rot_out}, 14'h1000);
        // R3: small constants
        run_one(32'd5, 0);
        chk(imm_out == 5 && rot_out == 0, "R3 five", {imm_out, rot_out}, 12'h050);
        run_one(32'd192, 0);
        chk(imm_out == 192 && rot_out == 0, "R3 192", {imm_out, rot_out}, 12'hC00);
        // R9: 768
        run_one(32'd768, 0);
        chk(fit_ok && imm_out == 3 && rot_out == 12, "R9 768", {imm_out, rot_out}, 12'h03C);
        // R4: non-encodable
        run_one(32'd259, 0);
        chk(!fit_ok && imm_out == 0 && rot_out == 0, "R4 259", {fit_ok, imm_out, rot_out}, 0);
        run_one(32'd1025, 0);
        chk(!fit_ok && imm_out == 0 && rot_out == 0, "R4 1025", {fit_ok, imm_out, rot_out}, 0);
        // R7: start held during a search is ignored (259 stays unencodable)
        run_one(32'd259, 1);
        chk(!fit_ok, "R7 ignored start", fit_ok, 0);

        // R2/R3/R6: full sweep of byte x even rotation
        for (int im = 0; im < 256; im++) begin
            for (int r = 0; r < 16; r++) begin
                run_one(ror32(32'(im), 2 * r), 0);
            end
        end

        // R4: scattered words, mostly unencodable
        x = 32'h2545F491;
        for (int i = 0; i < 300; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            run_one(x, 0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule